// File: doc/BRIEF.md
# Inbound Message Queue Counter

This block keeps the number of entries waiting on an inbound message queue, between an external bus and a local processor. A bus master writes an entry to the queue's port. The bus side turns that write into a one-cycle post strobe, and the strobe adds one to the count. The local processor changes the count through a single write port. The top bit of its write data picks the action: when that bit is clear, the write removes one entry; when it is set, the write loads a new count.

The count can be read at any time on a 32-bit read bus. While the count is nonzero, the block raises two interrupt requests toward the local processor, a normal one and a fast one. Each request is gated by its own enable input. The queue storage, the address decoding and the interrupt controller are outside this block.

Top module: `inbound_msg_counter`

## Requirements
- R1: After reset, the count is 0 and both interrupt requests are low.
- R2: Bits 31:16 of `rd_data` always read 0. Bits 15:0 carry the count.
- R3: A cycle with `post_strobe` high and `wr_en` low raises the count by one on the next clock edge.
- R4: A write with `wr_data[31]` = 0 lowers the count by one. Bits 30:0 of that write have no effect.
- R5: A write with `wr_data[31]` = 1 loads `wr_data[15:0]` into the count. Bits 30:16 are ignored.
- R6: A decrement write in the same cycle as a post leaves the count unchanged. This also holds at 0 and at 16'hFFFF.
- R7: A load write in the same cycle as a post leaves the loaded value plus one, saturating at 16'hFFFF.
- R8: A post with the count at 16'hFFFF leaves the count at 16'hFFFF.
- R9: A decrement with the count at 0 leaves the count at 0.
- R10: `irq_req` is high exactly when the count is nonzero and `irq_en` is high.
- R11: `fiq_req` is high exactly when the count is nonzero and `fiq_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_strobe | input | 1 | One-cycle pulse for each entry a bus master posts |
| wr_en | input | 1 | Local processor write to the counter |
| wr_data | input | 32 | Local write data; bit 31 selects load (1) or decrement (0) |
| irq_en | input | 1 | Enable for the normal interrupt request |
| fiq_en | input | 1 | Enable for the fast interrupt request |
| rd_data | output | 32 | Count in bits 15:0, zeros above |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count in a 32-bit data word, with the load flag in bit 31. Because the full count width is used, a single load can put the count next to the ceiling. The saturation corners, including a post that coincides with a load of 16'hFFFF, can then be reached in a few cycles, with no need to post 65,535 times. The zero floor, the coinciding post and decrement at both ends, and the two interrupt enables on their own are each driven and compared with a model of the rules above.

// File: rtl/inbound_msg_counter.sv
module inbound_msg_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_strobe,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              fiq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req,
  output logic              fiq_req
);

  localparam int               FLAG    = DATA_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             is_load, is_dec, nonzero;
  logic             unused_wr_bits;

  assign is_load        = wr_en & wr_data[FLAG];
  assign is_dec         = wr_en & ~wr_data[FLAG];
  assign load_val       = wr_data[CNT_W-1:0];
  assign unused_wr_bits = ^wr_data[FLAG-1:CNT_W];

  always_comb begin
    cnt_d = cnt_q;
    if (is_load) begin
      cnt_d = load_val;
      if (post_strobe && load_val != CNT_MAX) cnt_d = load_val + ONE;
    end else if (is_dec) begin
      if (!post_strobe && cnt_q != '0) cnt_d = cnt_q - ONE;
    end else if (post_strobe && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nonzero = cnt_q != '0;
  assign rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
  assign irq_req = nonzero & irq_en;
  assign fiq_req = nonzero & fiq_en;

  // R3
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_strobe && !wr_en && rd_data[CNT_W-1:0] != CNT_MAX)
      |=> rd_data[CNT_W-1:0] == $past(rd_data[CNT_W-1:0]) + ONE);

  // R4
  local_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[FLAG] && !post_strobe && rd_data[CNT_W-1:0] != '0)
      |=> rd_data[CNT_W-1:0] == $past(rd_data[CNT_W-1:0]) - ONE);

  // R5
  local_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLAG] && !post_strobe)
      |=> rd_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]));

  // R6
  inc_dec_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[FLAG] && post_strobe) |=> $stable(rd_data));

  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_strobe && !wr_en && rd_data[CNT_W-1:0] == CNT_MAX)
      |=> rd_data[CNT_W-1:0] == CNT_MAX);

  // R9
  floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[FLAG] && !post_strobe && rd_data[CNT_W-1:0] == '0)
      |=> rd_data[CNT_W-1:0] == '0);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_en && rd_data != '0));

  // R11
  fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> (fiq_en && rd_data != '0));

endmodule

// File: tb/test_inbound_msg_counter.sv
module test_inbound_msg_counter;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        post_strobe = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic        irq_en = 0;
  logic        fiq_en = 0;
  logic [31:0] rd_data;
  logic        irq_req, fiq_req;

  always #(PERIOD/2) clk = ~clk;

  inbound_msg_counter i_inbound_msg_counter (
    .clk(clk), .rst_n(rst_n), .post_strobe(post_strobe), .wr_en(wr_en),
    .wr_data(wr_data), .irq_en(irq_en), .fiq_en(fiq_en),
    .rd_data(rd_data), .irq_req(irq_req), .fiq_req(fiq_req)
  );

  logic [31:0] exp_rd_q[$];
  logic        exp_irq_q[$];
  logic        exp_fiq_q[$];
  string       tag_q[$];

  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic [15:0] model = '0;

  task automatic push_exp(input string tag);
    exp_rd_q.push_back({16'h0, model});
    exp_irq_q.push_back((model != 0) && irq_en);
    exp_fiq_q.push_back((model != 0) && fiq_en);
    tag_q.push_back(tag);
  endtask

  task automatic apply(input bit p, input bit w, input logic [31:0] d,
                       input bit ie, input bit fe, input string tag);
    @(negedge clk);
    post_strobe = p; wr_en = w; wr_data = d; irq_en = ie; fiq_en = fe;
    if (w && d[31]) begin
      model = d[15:0];
      if (p && model != 16'hFFFF) model = model + 16'd1;
    end else if (w) begin
      if (!p && model != 0) model = model - 16'd1;
    end else if (p && model != 16'hFFFF) begin
      model = model + 16'd1;
    end
    @(posedge clk);
    #1;
    push_exp(tag);
    @(negedge clk);
    post_strobe = 0; wr_en = 0; wr_data = '0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      while (exp_rd_q.size() > 0) begin
        logic [31:0] er;
        logic ei, ef;
        string t;
        er = exp_rd_q.pop_front();
        ei = exp_irq_q.pop_front();
        ef = exp_fiq_q.pop_front();
        t  = tag_q.pop_front();
        n_checks++;
        if (rd_data !== er || irq_req !== ei || fiq_req !== ef) begin
          n_fail++;
          $display("FAIL %s: rd=%h irq=%b fiq=%b expected rd=%h irq=%b fiq=%b",
                   t, rd_data, irq_req, fiq_req, er, ei, ef);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    irq_en = 1; fiq_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    push_exp("R1 reset state");
    apply(1, 0, 32'h0, 1, 0, "R3 post from 0");
    apply(1, 0, 32'h0, 1, 0, "R3 second post");
    apply(1, 0, 32'h0, 1, 0, "R10 irq with count 3");
    apply(0, 1, 32'h7FFF_ABCD, 1, 0, "R4 decrement ignores low bits");
    apply(0, 1, 32'h8123_0005, 1, 0, "R5 load, R2 upper zero");
    apply(1, 1, 32'h0000_0000, 1, 0, "R6 post with decrement");
    apply(1, 1, 32'h8000_0010, 1, 0, "R7 load plus post");
    apply(0, 1, 32'h8000_FFFE, 1, 0, "R5 load near top");
    apply(1, 0, 32'h0, 1, 0, "R3 post reaches top");
    apply(1, 0, 32'h0, 1, 0, "R8 post at top holds");
    apply(1, 1, 32'h0, 1, 0, "R6 post with decrement at top");
    apply(1, 1, 32'h8000_FFFF, 1, 0, "R7 load top plus post saturates");
    apply(0, 1, 32'h8000_0001, 1, 1, "R5 load one");
    apply(0, 1, 32'h0000_0000, 1, 1, "R4 decrement to 0");
    apply(0, 1, 32'h0000_0000, 1, 1, "R9 decrement at 0 holds");
    apply(1, 1, 32'h0000_0000, 1, 1, "R6 post with decrement at 0");
    apply(0, 1, 32'h8000_0003, 0, 1, "R11 fiq alone");
    apply(0, 0, 32'h0, 1, 0, "R10 irq alone");
    apply(0, 0, 32'h0, 0, 0, "R10 R11 both masked");
    apply(0, 1, 32'hFFFF_0000, 1, 1, "R5 load zero drops requests");
    apply(0, 0, 32'h0, 1, 1, "R1 idle holds");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule